// File: doc/BRIEF.md
# Soft Mute Ramp with Zero Watch

This block sits in a two-channel per-sample audio path, between the serial input stage and the interpolation filter. On every sample strobe it takes a signed 24-bit left and right sample, applies a common attenuation and registers the result. When the mute input is high, the attenuation grows by 0.5 dB on each sample until the output sits exactly at bipolar zero (code 0). When mute goes low, the attenuation shrinks by 0.5 dB per sample back to unity gain. Because the gain changes by at most one step per sample, muting never produces an audible click.

The attenuation is an index from 0 to 255, one count per 0.5 dB. Gain is applied as a multiply by a Q1.15 mantissa taken from twelve half-decibel steps. That product is then shifted right once for each whole 6 dB of attenuation. The quotient is truncated toward zero.

Alongside the gain path, a watcher counts consecutive samples in which both input channels are exactly zero. It raises a zero flag when that run is long enough. Any nonzero input clears the flag in the same sample.

Top module: `smute_ramp_top`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets: dout_vld, dout_l, dout_r and zero_flag become 0 and the attenuation index becomes 0.
- R2: With attenuation index 0, each output sample equals its input sample exactly, including the codes 0x7FFFFF and 0x800000.
- R3: Output samples are produced as follows.
  - Index i below 255 gives an output of trunc(x * M[i mod 12] / 2^(15 + i div 12)), truncated toward zero.
  - M is, for the remainders 0 to 11: 32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396.
  - Each sample uses the index that held before that strobe.
  - With mute high, each strobe raises the index by one, up to 255.
- R4: While the index is 255, both outputs are exactly 0.
- R5: With mute low, each strobe lowers the index by one, until it reaches 0.
- R6: Changing mute partway through a ramp reverses the direction at the next strobe, starting from the current index.
- R7: The index changes only on a strobe, and by at most one count.
- R8: zero_flag goes high with the output of the 1024th consecutive strobe whose left and right inputs are both 0. It stays high while such strobes continue.
- R9: A strobe with a nonzero sample on either channel clears zero_flag with that strobe's output. It also restarts the zero run.
- R10: Negative samples are scaled with truncation toward zero, so their magnitude matches that of the mirrored positive sample.
- R11: dout_vld is high exactly in the cycle after a strobe. Between strobes, dout_l, dout_r and zero_flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample strobe, one cycle per sample period |
| mute | input | 1 | High: ramp toward zero; low: ramp toward unity |
| din_l | input | 24 | Left input sample, two's complement |
| din_r | input | 24 | Right input sample, two's complement |
| dout_vld | output | 1 | High for one cycle when new outputs are presented |
| dout_l | output | 24 | Attenuated left sample |
| dout_r | output | 24 | Attenuated right sample |
| zero_flag | output | 1 | High after a long run of all-zero input pairs |

## Verification
The hardest states to reach from the ports are the far end of the ramp and a reversal midway through it. Both depend on a history of hundreds of strobes with mute held at the right level. The stimulus therefore walks the index through every value from 0 to 255 and back down, using a full-scale positive pattern on the left channel and a negative pattern on the right. It reverses mute midway and checks every output against a reference model of the index. The zero flag is driven to the boundary with exactly 1023 and then 1024 zero pairs. It is then cleared by a nonzero sample on each channel in turn.

// File: rtl/smute_pkg.sv
// Shared constants and the half-decibel mantissa table for the soft mute path.
// Assumes a Q1.15 gain mantissa and twelve 0.5 dB steps per 6 dB (one shift).
package smute_pkg;
    localparam int unsigned FRAC_BITS     = 15;
    localparam int unsigned MANT_W        = 16;
    localparam int unsigned STEPS_PER_OCT = 12;
    localparam int unsigned NUM_CH        = 2;

    // Gain 10^(-k/40) in Q1.15 for k = 0..11.
    function automatic logic [MANT_W-1:0] step_mant(input int unsigned k);
        case (k)
            0:       return 16'd32768;
            1:       return 16'd30935;
            2:       return 16'd29205;
            3:       return 16'd27571;
            4:       return 16'd26029;
            5:       return 16'd24573;
            6:       return 16'd23198;
            7:       return 16'd21900;
            8:       return 16'd20675;
            9:       return 16'd19519;
            10:      return 16'd18427;
            11:      return 16'd17396;
            default: return 16'd0;
        endcase
    endfunction
endpackage

// File: rtl/smute_ramp_ctrl.sv
// Attenuation index counter: steps up once per strobe while mute is high,
// down once per strobe while mute is low, saturating at 0 and IDX_MAX.
// Assumes smp_vld is a single-cycle strobe.
module smute_ramp_ctrl #(
    parameter int unsigned IDX_MAX = 255,
    localparam int unsigned IDX_W  = $clog2(IDX_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic             mute,
    output logic [IDX_W-1:0] idx
);
    // Move the index one step per sample in the direction mute selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (smp_vld) begin
            if (mute && idx != IDX_W'(IDX_MAX))
                idx <= idx + 1'b1;
            else if (!mute && idx != '0)
                idx <= idx - 1'b1;
        end
    end
endmodule

// File: rtl/smute_gain_apply.sv
// Combinational gain stage for one channel: multiplies by the mantissa for
// the fractional step, then shifts right once per whole 6 dB, and truncates
// toward zero. Forces zero at the last index. Assumes the largest shift
// fits inside the product width.
module smute_gain_apply
    import smute_pkg::*;
#(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned IDX_MAX = 255,
    localparam int unsigned IDX_W  = $clog2(IDX_MAX + 1),
    localparam int unsigned PW     = DATA_W + MANT_W + 1
) (
    input  logic [DATA_W-1:0] x,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] y
);
    logic [IDX_W-1:0]     oct;
    logic [IDX_W-1:0]     frac;
    logic [MANT_W-1:0]    mant;
    int unsigned          sh;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] bias;
    logic signed [PW-1:0] rnd;

    // Split the index into whole shifts and a table step.
    always_comb begin
        oct  = idx / IDX_W'(STEPS_PER_OCT);
        frac = idx % IDX_W'(STEPS_PER_OCT);
        mant = step_mant(32'(frac));
        sh   = FRAC_BITS + 32'(oct);
    end

    // Multiply, bias negatives so the shift truncates toward zero, then shift.
    always_comb begin
        prod = $signed(x) * $signed({1'b0, mant});
        bias = (PW'(1) << sh) - PW'(1);
        rnd  = prod[PW-1] ? prod + bias : prod;
        if (idx == IDX_W'(IDX_MAX))
            y = '0;
        else
            y = DATA_W'(rnd >>> sh);
    end
endmodule

// File: rtl/smute_zero_watch.sv
// Counts consecutive strobes in which both channels are exactly zero and
// raises the flag once the run reaches ZERO_RUN. A nonzero sample clears the
// run and the flag on the same strobe. The counter saturates.
module smute_zero_watch #(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned ZERO_RUN = 1024,
    localparam int unsigned CNT_W   = $clog2(ZERO_RUN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] din_l,
    input  logic [DATA_W-1:0] din_r,
    output logic              zero_flag
);
    logic [CNT_W-1:0] run_cnt;
    logic             both_zero;

    // Both channels silent on this sample.
    assign both_zero = (din_l == '0) && (din_r == '0);

    // Track the run length and update the flag on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            zero_flag <= 1'b0;
        end else if (smp_vld) begin
            if (both_zero) begin
                if (run_cnt != CNT_W'(ZERO_RUN))
                    run_cnt <= run_cnt + 1'b1;
                zero_flag <= (run_cnt >= CNT_W'(ZERO_RUN - 1));
            end else begin
                run_cnt   <= '0;
                zero_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smute_ramp_top.sv
// Two-channel soft mute with zero detection. Each strobe registers both
// attenuated samples using the index that held before the strobe, and
// advances the index one step. Assumes strobes are at least two cycles apart.
module smute_ramp_top
    import smute_pkg::*;
#(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned IDX_MAX  = 255,
    parameter int unsigned ZERO_RUN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic              mute,
    input  logic [DATA_W-1:0] din_l,
    input  logic [DATA_W-1:0] din_r,
    output logic              dout_vld,
    output logic [DATA_W-1:0] dout_l,
    output logic [DATA_W-1:0] dout_r,
    output logic              zero_flag
);
    localparam int unsigned IDX_W = $clog2(IDX_MAX + 1);

    logic [IDX_W-1:0]  atten_idx;
    logic [DATA_W-1:0] ch_in  [NUM_CH];
    logic [DATA_W-1:0] ch_out [NUM_CH];

    assign ch_in[0] = din_l;
    assign ch_in[1] = din_r;

    smute_ramp_ctrl #(.IDX_MAX(IDX_MAX)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .mute    (mute),
        .idx     (atten_idx)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        smute_gain_apply #(.DATA_W(DATA_W), .IDX_MAX(IDX_MAX)) i_gain (
            .x   (ch_in[ch]),
            .idx (atten_idx),
            .y   (ch_out[ch])
        );
    end

    smute_zero_watch #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) i_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .din_l     (din_l),
        .din_r     (din_r),
        .zero_flag (zero_flag)
    );

    // Register the scaled samples and the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_vld <= 1'b0;
            dout_l   <= '0;
            dout_r   <= '0;
        end else begin
            dout_vld <= smp_vld;
            if (smp_vld) begin
                dout_l <= ch_out[0];
                dout_r <= ch_out[1];
            end
        end
    end
endmodule

// File: rtl/smute_ramp_chk.sv
// Checker for the soft mute block: output strobe timing, index stepping,
// forced silence at full attenuation, and zero flag consistency.
module smute_ramp_chk #(
    parameter int unsigned DATA_W  = 24,
    parameter int unsigned IDX_MAX = 255,
    localparam int unsigned IDX_W  = $clog2(IDX_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic              mute,
    input logic [DATA_W-1:0] din_l,
    input logic [DATA_W-1:0] din_r,
    input logic              dout_vld,
    input logic [DATA_W-1:0] dout_l,
    input logic [DATA_W-1:0] dout_r,
    input logic              zero_flag,
    input logic [IDX_W-1:0]  idx
);
    // R11
    vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> dout_vld);

    // R11
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !dout_vld);

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> ($stable(dout_l) && $stable(dout_r) && $stable(zero_flag)));

    // R7
    idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(idx));

    // R7
    idx_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != $past(idx)) |-> (idx == $past(idx) + 1'b1 || idx + 1'b1 == $past(idx)));

    // R3
    idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && mute && idx != IDX_W'(IDX_MAX)) |=> idx == $past(idx) + 1'b1);

    // R5
    idx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !mute && idx != '0) |=> idx + 1'b1 == $past(idx));

    // R4
    full_mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && $past(idx) == IDX_W'(IDX_MAX)) |-> (dout_l == '0 && dout_r == '0));

    // R9
    flag_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && zero_flag) |-> ($past(din_l) == '0 && $past(din_r) == '0));
endmodule

bind smute_ramp_top smute_ramp_chk #(.DATA_W(DATA_W), .IDX_MAX(IDX_MAX)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .mute      (mute),
    .din_l     (din_l),
    .din_r     (din_r),
    .dout_vld  (dout_vld),
    .dout_l    (dout_l),
    .dout_r    (dout_r),
    .zero_flag (zero_flag),
    .idx       (atten_idx)
);

// File: tb/test_smute_ramp_top.sv
module test_smute_ramp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic        mute = 1'b0;
    logic [23:0] din_l = '0;
    logic [23:0] din_r = '0;
    logic        dout_vld;
    logic [23:0] dout_l;
    logic [23:0] dout_r;
    logic        zero_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int idx_m = 0;
    int zrun  = 0;
    int mt [12] = '{32768, 30935, 29205, 27571, 26029, 24573,
                    23198, 21900, 20675, 19519, 18427, 17396};

    always #4 clk = ~clk;

    smute_ramp_top i_smute_ramp_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .mute      (mute),
        .din_l     (din_l),
        .din_r     (din_r),
        .dout_vld  (dout_vld),
        .dout_l    (dout_l),
        .dout_r    (dout_r),
        .zero_flag (zero_flag)
    );

    function automatic logic [23:0] ref_scale(input logic [23:0] x, input int i);
        longint p;
        longint d;
        if (i >= 255) return 24'd0;
        p = longint'($signed(x)) * longint'(mt[i % 12]);
        d = longint'(1) << (15 + i / 12);
        return 24'(p / d);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One sample period: strobe for one cycle, then check the registered result.
    task automatic send(input logic [23:0] l, input logic [23:0] r, input bit m,
                        input string tl, input string tr, input string tf);
        logic [23:0] el;
        logic [23:0] er;
        bit          ef;
        el = ref_scale(l, idx_m);
        er = ref_scale(r, idx_m);
        if (l == 0 && r == 0) zrun = (zrun < 1024) ? zrun + 1 : zrun;
        else zrun = 0;
        ef = (zrun >= 1024);
        if (m && idx_m < 255) idx_m++;
        else if (!m && idx_m > 0) idx_m--;
        @(negedge clk);
        smp_vld = 1'b1; mute = m; din_l = l; din_r = r;
        @(negedge clk);
        smp_vld = 1'b0;
        chk(dout_vld == 1'b1, "R11 vld", longint'(dout_vld), 1);
        chk(dout_l == el, tl, longint'($signed(dout_l)), longint'($signed(el)));
        chk(dout_r == er, tr, longint'($signed(dout_r)), longint'($signed(er)));
        chk(zero_flag == ef, tf, longint'(zero_flag), longint'(ef));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] l;
        logic [23:0] r;
        logic [23:0] hl;
        logic [23:0] hr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(dout_vld == 0 && dout_l == 0 && dout_r == 0 && zero_flag == 0,
            "R1 reset", longint'(dout_l), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_vld == 0, "R1 idle vld", longint'(dout_vld), 0);

        // R2 unity gain with extreme and varied codes
        send(24'h7FFFFF, 24'h800000, 0, "R2 l", "R2 r", "R9 flag");
        send(24'h000001, 24'hFFFFFF, 0, "R2 l", "R2 r", "R9 flag");
        for (int k = 0; k < 20; k++) begin
            l = 24'(k * 419431 + 17);
            r = 24'(-(k * 300007 + 5));
            send(l, r, 0, "R2 l", "R2 r", "R9 flag");
        end

        // R3/R4 full downward ramp: positive left, negative right (R10)
        for (int k = 0; k < 262; k++) begin
            l = 24'h7FFFFF - 24'(k * 1234);
            r = 24'h800000 + 24'(k * 977);
            send(l, r, 1, (idx_m >= 255) ? "R4 l" : "R3 l",
                 (idx_m >= 255) ? "R4 r" : "R10 r", "R9 flag");
        end

        // R5 partial release
        for (int k = 0; k < 100; k++) begin
            l = 24'(k * 65537 + 3);
            r = 24'(-(k * 54321 + 7));
            send(l, r, 0, "R5 l", "R10 r", "R9 flag");
        end
        // R6 reversal mid-ramp, then back again
        for (int k = 0; k < 30; k++)
            send(24'h654321, 24'h9ABCDF, 1, "R6 l", "R6 r", "R9 flag");
        for (int k = 0; k < 190; k++)
            send(24'h400000 + 24'(k), 24'hC00000 - 24'(k), 0, "R5 l", "R5 r", "R9 flag");
        chk(idx_m == 0, "R5 model", longint'(idx_m), 0);
        send(24'h7FFFFF, 24'h800000, 0, "R5 unity l", "R5 unity r", "R9 flag");

        // R11/R7 idle cycles: outputs hold, attenuation unchanged
        send(24'h123456, 24'hEDCBA9, 1, "R3 l", "R10 r", "R9 flag");
        hl = dout_l; hr = dout_r;
        repeat (6) @(negedge clk);
        chk(dout_l == hl && dout_r == hr && dout_vld == 0, "R11 hold",
            longint'(dout_l), longint'(hl));
        send(24'h123456, 24'hEDCBA9, 1, "R7 l", "R7 r", "R9 flag");
        for (int k = 0; k < 10; k++)
            send(24'h200000, 24'hE00000, 0, "R5 l", "R5 r", "R9 flag");

        // R8 zero run boundary
        for (int k = 0; k < 1023; k++)
            send(24'd0, 24'd0, k[0], "R8 l", "R8 r", "R8 flag");
        chk(zero_flag == 0, "R8 before", longint'(zero_flag), 0);
        send(24'd0, 24'd0, 0, "R8 l", "R8 r", "R8 flag");
        chk(zero_flag == 1, "R8 at run", longint'(zero_flag), 1);
        for (int k = 0; k < 5; k++)
            send(24'd0, 24'd0, 0, "R8 l", "R8 r", "R8 flag");
        // R9 right channel nonzero clears
        send(24'd0, 24'd1, 0, "R9 l", "R9 r", "R9 flag");
        chk(zero_flag == 0, "R9 right", longint'(zero_flag), 0);
        for (int k = 0; k < 1024; k++)
            send(24'd0, 24'd0, 0, "R8 l", "R8 r", "R8 flag");
        chk(zero_flag == 1, "R8 second run", longint'(zero_flag), 1);
        // R9 left channel nonzero clears
        send(24'hFFFFFF, 24'd0, 0, "R9 l", "R9 r", "R9 flag");
        chk(zero_flag == 0, "R9 left", longint'(zero_flag), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule